// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block keeps a small set of recently used address translations so that most memory accesses avoid a page table walk. A lookup presents a virtual page number. In the same cycle the block answers with either a hit, which carries the physical page number and the page's dirty status, or a miss, which tells the surrounding logic that a walk is needed. When the walk finishes, its result is installed through a fill port. A lookup that is also a write marks its entry dirty, so the page can be written back later.

Every entry is searched in parallel, and the tag is the full virtual page number. A fill goes to the lowest free slot. When no slot is free, a round-robin pointer selects the victim. A fill for a page that is already resident refreshes that entry instead of adding a second copy. A one-cycle flush, raised when the running process changes, drops every translation at once. The flush takes priority over any lookup or fill in the same cycle.

Top module: `fa_tlb`

## Requirements
- R1: After reset no entry is valid: every lookup misses until a fill has been made.
- R2: A lookup whose VPN matches a valid entry raises `lk_hit` in the same cycle, with that entry's PPN on `lk_ppn` and its dirty bit on `lk_dirty`.
- R3: A lookup with no matching valid entry raises `lk_miss` and leaves `lk_hit` low. When `lk_valid` is low, both outputs stay low.
- R4: A fill goes to the lowest-indexed invalid entry. The block holds `ENTRIES` distinct translations before it replaces anything.
- R5: When every entry is valid, a fill of a new VPN replaces the entry at the round-robin pointer. The pointer starts at index 0 and advances by one, wrapping, on each such replacement.
- R6: A fill for a VPN that is already valid overwrites that entry's PPN and dirty bit and uses no extra slot. A VPN never occupies two entries.
- R7: A lookup with `lk_write` high that hits sets the entry's dirty bit, and later lookups report it. `lk_dirty` in the write cycle shows the value held before the write. A write that misses changes nothing.
- R8: `flush` invalidates every entry in one cycle. A lookup in the same cycle reports a miss, and a fill in the same cycle is discarded.
- R9: A flush returns the round-robin pointer to index 0, so after a refill the first replacement evicts entry 0.
- R10: A fill stores `fill_dirty` as the entry's initial dirty bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries (process switch) |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is a write access |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Lookup found a valid translation |
| lk_miss | output | 1 | Lookup needs a page table walk |
| lk_ppn | output | PPN_W | Physical page number on a hit |
| lk_dirty | output | 1 | Dirty bit of the hitting entry |
| fill_valid | input | 1 | Install a translation this cycle |
| fill_vpn | input | VPN_W | VPN of the translation to install |
| fill_ppn | input | PPN_W | PPN of the translation to install |
| fill_dirty | input | 1 | Initial dirty bit of the installed entry |

## Verification
The lookup path is exercised with hits on a single entry, misses on close neighbouring VPNs, reads and writes to the same page, and refills of a resident VPN. Together these separate correct tag matching from data forwarding and from the dirty update. The table is then filled to capacity with distinct pages, and further fills show which entry each replacement removes. That order shows whether free slots are used before eviction, whether a duplicate fill wrongly takes a slot, and whether the pointer is reset. A flush raised together with a lookup and a fill shows that the flush takes priority in that cycle.

// File: rtl/fa_tlb.sv
module fa_tlb #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic             lk_write,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_dirty,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_dirty
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q, dirty_q, lk_match, fl_match;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IW-1:0]      rr_q, lk_idx, fl_idx, free_idx, victim;
  logic               free_any, fl_resident, do_fill, evict, wr_hit;

  // lowest index wins for every priority pick
  always_comb begin
    lk_idx   = '0;
    fl_idx   = '0;
    free_idx = '0;
    free_any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      lk_match[i] = valid_q[i] && (tag_q[i] == lk_vpn);
      fl_match[i] = valid_q[i] && (tag_q[i] == fill_vpn);
      if (lk_match[i]) lk_idx = IW'(i);
      if (fl_match[i]) fl_idx = IW'(i);
      if (!valid_q[i]) begin
        free_idx = IW'(i);
        free_any = 1'b1;
      end
    end
  end

  assign lk_hit      = lk_valid && !flush && (|lk_match);
  assign lk_miss     = lk_valid && !lk_hit;
  assign lk_ppn      = ppn_q[lk_idx];
  assign lk_dirty    = lk_hit && dirty_q[lk_idx];
  assign wr_hit      = lk_hit && lk_write;
  assign fl_resident = |fl_match;
  assign do_fill     = fill_valid && !flush;
  assign evict       = do_fill && !fl_resident && !free_any;
  assign victim      = fl_resident ? fl_idx : (free_any ? free_idx : rr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      rr_q    <= '0;
    end else if (flush) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      if (wr_hit) dirty_q[lk_idx] <= 1'b1;
      if (do_fill) begin
        valid_q[victim] <= 1'b1;
        dirty_q[victim] <= fill_dirty;
      end
      if (evict) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[victim] <= fill_vpn;
      ppn_q[victim] <= fill_ppn;
    end
  end

  AST_UNIQUE_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));  // R6

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> (valid_q == '0));  // R8

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_valid && !flush) && lk_valid && !flush && (lk_vpn == $past(fill_vpn)))
      |-> (lk_hit && (lk_ppn == $past(fill_ppn))));  // R2

  AST_DIRTY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lk_hit && lk_write) && !$past(fill_valid) && lk_valid && !flush
      && (lk_vpn == $past(lk_vpn))) |-> (lk_hit && lk_dirty));  // R7

  AST_EVICT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ((rr_q != $past(rr_q)) && !$past(flush)) |-> ($past(valid_q) == '1));  // R5
endmodule

// File: tb/tb_fa_tlb.sv
`timescale 1ns/1ps
module tb_fa_tlb;
  localparam int ENTRIES = 64;
  localparam int VPN_W   = 20;
  localparam int PPN_W   = 12;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic lk_valid = 1'b0, lk_write = 1'b0, fill_valid = 1'b0, fill_dirty = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic lk_hit, lk_miss, lk_dirty;
  logic [PPN_W-1:0] lk_ppn;
  int checks = 0, errors = 0;

  typedef struct {
    logic             hit;
    logic [PPN_W-1:0] ppn;
    logic             dirty;
    string            req;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  fa_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_write(lk_write), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_ppn(lk_ppn), .lk_dirty(lk_dirty),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_dirty(fill_dirty)
  );

  function automatic logic [PPN_W-1:0] pp(input logic [VPN_W-1:0] v);
    return v[PPN_W-1:0] ^ 12'h5A3;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic lookup(input logic [VPN_W-1:0] v, input logic wr, input logic hit,
                        input logic [PPN_W-1:0] p, input logic d, input string req);
    exp_t e;
    e.hit = hit; e.ppn = p; e.dirty = d; e.req = req;
    @(negedge clk);
    sb.push_back(e);
    lk_valid = 1'b1; lk_write = wr; lk_vpn = v;
    @(negedge clk);
    lk_valid = 1'b0; lk_write = 1'b0;
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p, input logic d);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = v; fill_ppn = p; fill_dirty = d;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // monitor: compares each lookup result with the queued expectation
  initial forever begin
    @(negedge clk);
    #1;
    if (lk_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL monitor: result with no expectation, hit=%0b", lk_hit);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.hit) begin
          if (!(lk_hit && !lk_miss && lk_ppn == e.ppn && lk_dirty == e.dirty)) begin
            errors++;
            $display("FAIL %s: vpn=%h hit=%0b miss=%0b ppn=%h dirty=%0b, expected hit ppn=%h dirty=%0b",
                     e.req, lk_vpn, lk_hit, lk_miss, lk_ppn, lk_dirty, e.ppn, e.dirty);
          end
        end else if (!(lk_miss && !lk_hit)) begin
          errors++;
          $display("FAIL %s: vpn=%h hit=%0b miss=%0b, expected miss",
                   e.req, lk_vpn, lk_hit, lk_miss);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    checks++;  // R3 idle outputs
    if (lk_hit || lk_miss) begin
      errors++;
      $display("FAIL R3: idle hit=%0b miss=%0b, expected 0 0", lk_hit, lk_miss);
    end
    lookup(20'h00005, 0, 0, '0, 0, "R1");
    lookup(20'h00100, 0, 0, '0, 0, "R1");

    fill(20'h00100, 12'h011, 0);
    lookup(20'h00100, 0, 1, 12'h011, 0, "R2");
    lookup(20'h00101, 0, 0, '0, 0, "R3");
    lookup(20'h80100, 0, 0, '0, 0, "R3");

    lookup(20'h00100, 1, 1, 12'h011, 0, "R7");
    lookup(20'h00100, 0, 1, 12'h011, 1, "R7");
    lookup(20'h00555, 1, 0, '0, 0, "R7");
    fill(20'h00555, 12'h055, 0);
    lookup(20'h00555, 0, 1, 12'h055, 0, "R7");

    fill(20'h00100, 12'h022, 0);
    lookup(20'h00100, 0, 1, 12'h022, 0, "R6");

    fill(20'h00200, 12'h033, 1);
    lookup(20'h00200, 0, 1, 12'h033, 1, "R10");

    // slots 3..63 take the rest; the duplicate fill above used no slot
    for (int i = 0; i < ENTRIES - 3; i++) fill(20'h01000 + VPN_W'(i), pp(20'h01000 + VPN_W'(i)), 0);
    lookup(20'h00100, 0, 1, 12'h022, 0, "R4");
    lookup(20'h00555, 0, 1, 12'h055, 0, "R4");
    lookup(20'h00200, 0, 1, 12'h033, 1, "R4");
    lookup(20'h01000, 0, 1, pp(20'h01000), 0, "R4");
    lookup(20'h0103C, 0, 1, pp(20'h0103C), 0, "R6");

    fill(20'h09000, 12'h090, 0);
    lookup(20'h00100, 0, 0, '0, 0, "R5");
    lookup(20'h09000, 0, 1, 12'h090, 0, "R5");
    lookup(20'h00555, 0, 1, 12'h055, 0, "R5");
    fill(20'h09001, 12'h091, 0);
    lookup(20'h00555, 0, 0, '0, 0, "R5");
    lookup(20'h00200, 0, 1, 12'h033, 1, "R5");

    // R8: flush, lookup and fill in one cycle
    begin
      exp_t e;
      e.hit = 1'b0; e.ppn = '0; e.dirty = 1'b0; e.req = "R8";
      @(negedge clk);
      sb.push_back(e);
      flush = 1'b1; lk_valid = 1'b1; lk_vpn = 20'h00200;
      fill_valid = 1'b1; fill_vpn = 20'h07777; fill_ppn = 12'h777; fill_dirty = 1'b0;
      @(negedge clk);
      flush = 1'b0; lk_valid = 1'b0; fill_valid = 1'b0;
    end
    lookup(20'h07777, 0, 0, '0, 0, "R8");
    lookup(20'h00200, 0, 0, '0, 0, "R8");
    lookup(20'h09000, 0, 0, '0, 0, "R8");

    for (int i = 0; i < ENTRIES; i++) fill(20'h02000 + VPN_W'(i), pp(20'h02000 + VPN_W'(i)), 0);
    fill(20'h03000, 12'h300, 0);
    lookup(20'h02000, 0, 0, '0, 0, "R9");
    lookup(20'h02002, 0, 1, pp(20'h02002), 0, "R9");
    lookup(20'h03000, 0, 1, 12'h300, 0, "R9");
    fill(20'h03001, 12'h301, 0);
    lookup(20'h02001, 0, 0, '0, 0, "R9");

    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d results missing, expected 0", sb.size());
    end
    summary();
  end
endmodule